// File: doc/BRIEF.md
# Page Descriptor Access-Tracking Unit

This block holds the page descriptors of a memory management unit and judges every translated access against them. Each descriptor is a DW-bit word. Its low three bits hold a protection code that says whether the page is resident, whether it may be written, and whether an access should raise a memory-management trap. Bit 7 is the accessed flag and bit 6 is the written flag. The block keeps both flags up to date as accesses go by.

A register bus reads and writes descriptors. The address is a processor-mode number plus a 4-bit page select, in which bit 3 picks the instruction or data space and bits 2:0 pick the page. Reads are combinational. A write stores the data with both status flags cleared. The access-check port carries a mode, a page select, a read/write flag and a valid strobe. One cycle after the strobe, the block reports abort or trap, together with the descriptor as it stood before the access. A small sequencer has two states. ST_IDLE means no result is shown. ST_REPORT means a result is shown. Transition T_ACCEPT (IDLE to REPORT) and transition T_HOLD (REPORT to REPORT) are taken on a strobe. Transition T_DRAIN (REPORT to IDLE) is taken when there is no strobe.

Top module: `pdt_unit`

## Requirements
- R1: A synchronous reset clears every descriptor to zero and drives chk_abort, chk_trap and chk_desc low. Any access after reset therefore aborts.
- R2: A bus write stores bus_wdata with bits 7 and 6 forced to 0. bus_rdata always shows, combinationally, the descriptor selected by {bus_mode, bus_page}.
- R3: Protection codes 0, 3 and 7 abort both reads and writes.
- R4: Codes 1 and 2 abort writes. Code 2 reads, and all accesses under code 6, complete with neither abort nor trap.
- R5: A trap is raised for a read under code 1, for any access under code 4, and for a write under code 5. No other access raises a trap.
- R6: The accessed flag (bit 7) is set exactly when a trap is raised. Every other access leaves it unchanged.
- R7: The written flag (bit 6) is set by every write that does not abort.
- R8: An aborted access keeps chk_trap low and changes no descriptor bit.
- R9: chk_abort and chk_trap are valid in the cycle after chk_valid and are low after a cycle with no strobe. chk_desc shows the pre-access descriptor of the last access and holds it until the next access.
- R10: If a bus write and an access update hit the same descriptor in the same cycle, the bus write wins. The access is still reported from the pre-access contents.
- R11: An access changes only the descriptor selected by its own mode and page select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register-bus write enable |
| bus_mode | input | MODE_W | Register-bus mode select |
| bus_page | input | SPACE_W+PAGE_W | Register-bus space and page select |
| bus_wdata | input | DW | Register-bus write data |
| bus_rdata | output | DW | Register-bus read data, combinational |
| chk_valid | input | 1 | Access-check strobe |
| chk_mode | input | MODE_W | Mode of the checked access |
| chk_page | input | SPACE_W+PAGE_W | Space and page of the checked access |
| chk_write | input | 1 | 1 for a write, 0 for a read |
| chk_abort | output | 1 | Access aborted, one cycle after the strobe |
| chk_trap | output | 1 | Memory-management trap, one cycle after the strobe |
| chk_desc | output | DW | Pre-access descriptor of the last checked access |

## Verification
The bench sweeps all eight protection codes with both reads and writes, then reads each descriptor back. A design that set the accessed flag on every completed access, as a simpler design might, would show bit 7 set after a code-6 or code-2 access. A design that let aborted accesses touch the flags would show bit 6 set under code 1. Same-cycle collisions between a bus write and an access update are forced on purpose: a design that gave the access priority would read back a status flag set just after a write. Mode isolation and the hold of chk_desc across idle cycles are checked against a reference model on every clock, over a long run of random traffic aimed at a few pages.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    localparam int ACCESSED_BIT = 7;
    localparam int WRITTEN_BIT  = 6;
    localparam int CODE_W       = 3;

    typedef enum logic [CODE_W-1:0] {
        PC_ABSENT0   = 3'd0,
        PC_RD_TRAP   = 3'd1,
        PC_RD_ONLY   = 3'd2,
        PC_ABSENT3   = 3'd3,
        PC_RW_TRAPALL= 3'd4,
        PC_RW_TRAPWR = 3'd5,
        PC_RW_FREE   = 3'd6,
        PC_ABSENT7   = 3'd7
    } prot_code_e;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/pdt_prot_decode.sv
module pdt_prot_decode
    import pdt_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              is_write,
    output logic              abort,
    output logic              trap
);
    prot_code_e pc;
    assign pc = prot_code_e'(code);

    always_comb begin
        abort = 1'b0;
        trap  = 1'b0;
        unique case (pc)
            PC_ABSENT0, PC_ABSENT3, PC_ABSENT7: abort = 1'b1;
            PC_RD_TRAP: begin
                abort = is_write;
                trap  = !is_write;
            end
            PC_RD_ONLY:    abort = is_write;
            PC_RW_TRAPALL: trap  = 1'b1;
            PC_RW_TRAPWR:  trap  = is_write;
            PC_RW_FREE:    trap  = 1'b0;
            default: begin
                abort = 1'b1;
                trap  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pdt_desc_bank.sv
module pdt_desc_bank
    import pdt_pkg::*;
#(
    parameter int DW    = 16,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_set_acc,
    input  logic             upd_set_wr,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [DW-1:0]    rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [DW-1:0]    rd_b_data
);
    localparam int          N_ENT    = 1 << IDX_W;
    localparam logic [DW-1:0] ACC_MASK = DW'(1) << ACCESSED_BIT;
    localparam logic [DW-1:0] WR_MASK  = DW'(1) << WRITTEN_BIT;
    localparam logic [DW-1:0] KEEP     = ~(ACC_MASK | WR_MASK);

    logic [DW-1:0] ent [N_ENT];
    logic [DW-1:0] set_mask;

    assign set_mask = (upd_set_acc ? ACC_MASK : '0) | (upd_set_wr ? WR_MASK : '0);

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic hit_wr;
        logic hit_upd;
        assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(g));
        assign hit_upd = upd_en && (upd_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent[g] <= '0;
            end else if (hit_wr) begin
                ent[g] <= wr_data & KEEP;
            end else if (hit_upd) begin
                ent[g] <= ent[g] | set_mask;
            end
        end
    end

    assign rd_a_data = ent[rd_a_idx];
    assign rd_b_data = ent[rd_b_idx];
endmodule

// File: rtl/pdt_check_seq.sv
module pdt_check_seq
    import pdt_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic          abort_in,
    input  logic          trap_in,
    input  logic [DW-1:0] desc_in,
    output logic          abort_o,
    output logic          trap_o,
    output logic [DW-1:0] desc_o
);
    seq_state_e state, state_nx;
    logic          res_abort;
    logic          res_trap;
    logic [DW-1:0] res_desc;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (valid) state_nx = ST_REPORT;
            ST_REPORT: if (!valid) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_abort <= 1'b0;
            res_trap  <= 1'b0;
            res_desc  <= '0;
        end else if (valid) begin
            res_abort <= abort_in;
            res_trap  <= trap_in && !abort_in;
            res_desc  <= desc_in;
        end
    end

    always_comb begin
        abort_o = 1'b0;
        trap_o  = 1'b0;
        desc_o  = res_desc;
        unique case (state)
            ST_IDLE: ;
            ST_REPORT: begin
                abort_o = res_abort;
                trap_o  = res_trap;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pdt_unit.sv
module pdt_unit
    import pdt_pkg::*;
#(
    parameter int DW      = 16,
    parameter int MODE_W  = 2,
    parameter int SPACE_W = 1,
    parameter int PAGE_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_we,
    input  logic [MODE_W-1:0]          bus_mode,
    input  logic [SPACE_W+PAGE_W-1:0]  bus_page,
    input  logic [DW-1:0]              bus_wdata,
    output logic [DW-1:0]              bus_rdata,
    input  logic                       chk_valid,
    input  logic [MODE_W-1:0]          chk_mode,
    input  logic [SPACE_W+PAGE_W-1:0]  chk_page,
    input  logic                       chk_write,
    output logic                       chk_abort,
    output logic                       chk_trap,
    output logic [DW-1:0]              chk_desc
);
    localparam int SEL_W = SPACE_W + PAGE_W;
    localparam int IDX_W = MODE_W + SEL_W;

    logic [IDX_W-1:0] bus_idx;
    logic [IDX_W-1:0] chk_idx;
    logic [DW-1:0]    cur_desc;
    logic             dec_abort;
    logic             dec_trap;

    assign bus_idx = {bus_mode, bus_page};
    assign chk_idx = {chk_mode, chk_page};

    pdt_desc_bank #(.DW(DW), .IDX_W(IDX_W)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (bus_we),
        .wr_idx      (bus_idx),
        .wr_data     (bus_wdata),
        .upd_en      (chk_valid && !dec_abort),
        .upd_idx     (chk_idx),
        .upd_set_acc (dec_trap),
        .upd_set_wr  (chk_write),
        .rd_a_idx    (bus_idx),
        .rd_a_data   (bus_rdata),
        .rd_b_idx    (chk_idx),
        .rd_b_data   (cur_desc)
    );

    pdt_prot_decode u_dec (
        .code     (cur_desc[CODE_W-1:0]),
        .is_write (chk_write),
        .abort    (dec_abort),
        .trap     (dec_trap)
    );

    pdt_check_seq #(.DW(DW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .valid    (chk_valid),
        .abort_in (dec_abort),
        .trap_in  (dec_trap),
        .desc_in  (cur_desc),
        .abort_o  (chk_abort),
        .trap_o   (chk_trap),
        .desc_o   (chk_desc)
    );
endmodule

// File: rtl/pdt_unit_chk.sv
module pdt_unit_chk #(
    parameter int DW      = 16,
    parameter int MODE_W  = 2,
    parameter int SPACE_W = 1,
    parameter int PAGE_W  = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_we,
    input logic [MODE_W-1:0]         bus_mode,
    input logic [SPACE_W+PAGE_W-1:0] bus_page,
    input logic [DW-1:0]             bus_rdata,
    input logic                      chk_valid,
    input logic                      chk_write,
    input logic                      chk_abort,
    input logic                      chk_trap,
    input logic [DW-1:0]             chk_desc
);
    logic [2:0] code;
    assign code = chk_desc[2:0];

    AST_ABORT_MASKS_TRAP: assert property (@(posedge clk) disable iff (rst)
        chk_abort |-> !chk_trap); // R8

    AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
        !$past(chk_valid) |-> (!chk_abort && !chk_trap)); // R9

    AST_ABSENT_ABORTS: assert property (@(posedge clk) disable iff (rst)
        ($past(chk_valid) && !$past(rst) && (code == 3'd0 || code == 3'd3 || code == 3'd7))
        |-> chk_abort); // R3

    AST_READONLY_WRITE_ABORTS: assert property (@(posedge clk) disable iff (rst)
        ($past(chk_valid) && !$past(rst) && $past(chk_write) && (code == 3'd1 || code == 3'd2))
        |-> chk_abort); // R4

    AST_TRAP_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        chk_trap |-> (code == 3'd1 || code == 3'd4 || code == 3'd5)); // R5

    AST_BUS_WRITE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_we) && !$past(rst) && $stable(bus_mode) && $stable(bus_page))
        |-> (bus_rdata[7:6] == 2'b00)); // R2
endmodule

bind pdt_unit pdt_unit_chk #(
    .DW(DW), .MODE_W(MODE_W), .SPACE_W(SPACE_W), .PAGE_W(PAGE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_mode  (bus_mode),
    .bus_page  (bus_page),
    .bus_rdata (bus_rdata),
    .chk_valid (chk_valid),
    .chk_write (chk_write),
    .chk_abort (chk_abort),
    .chk_trap  (chk_trap),
    .chk_desc  (chk_desc)
);

// File: tb/tb_pdt_unit.sv
`timescale 1ns/1ps
module tb_pdt_unit;
    localparam int DW = 16, MODE_W = 2, SPACE_W = 1, PAGE_W = 3;
    localparam int SEL_W = SPACE_W + PAGE_W;
    localparam int NIDX  = 1 << (MODE_W + SEL_W);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_we = 1'b0;
    logic [MODE_W-1:0] bus_mode = '0;
    logic [SEL_W-1:0]  bus_page = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic chk_valid = 1'b0;
    logic [MODE_W-1:0] chk_mode = '0;
    logic [SEL_W-1:0]  chk_page = '0;
    logic chk_write = 1'b0;
    logic chk_abort, chk_trap;
    logic [DW-1:0] chk_desc;

    always #2.5 clk = ~clk;

    pdt_unit #(.DW(DW), .MODE_W(MODE_W), .SPACE_W(SPACE_W), .PAGE_W(PAGE_W)) dut (
        .clk(clk), .rst(rst),
        .bus_we(bus_we), .bus_mode(bus_mode), .bus_page(bus_page),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chk_valid(chk_valid), .chk_mode(chk_mode), .chk_page(chk_page),
        .chk_write(chk_write), .chk_abort(chk_abort), .chk_trap(chk_trap),
        .chk_desc(chk_desc)
    );

    int model [NIDX];
    int ex_abort, ex_trap, ex_desc;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Protection rules taken from the requirement tables (R3, R4, R5)
    function automatic void judge(int code, bit wr, output bit ab, output bit tr);
        ab = (code == 0) || (code == 3) || (code == 7) || (wr && (code == 1 || code == 2));
        tr = !ab && ((code == 1 && !wr) || code == 4 || (code == 5 && wr));
    endfunction

    task automatic step(bit bwe, int bm, int bp, int bd, bit cv, int cm, int cp, bit cw,
                        string tag);
        int bi, ci, pre;
        bit ab, tr;
        bus_we = bwe; bus_mode = MODE_W'(bm); bus_page = SEL_W'(bp); bus_wdata = DW'(bd);
        chk_valid = cv; chk_mode = MODE_W'(cm); chk_page = SEL_W'(cp); chk_write = cw;
        bi = (bm << SEL_W) | bp;
        ci = (cm << SEL_W) | cp;
        #1;
        check("R2 bus read", int'(bus_rdata), model[bi]);
        if (cv) begin
            pre = model[ci];
            judge(pre & 7, cw, ab, tr);
            ex_abort = ab; ex_trap = tr; ex_desc = pre;
            if (!ab) begin
                if (tr) model[ci] |= 'h80;   // R6
                if (cw) model[ci] |= 'h40;   // R7
            end
        end else begin
            ex_abort = 0; ex_trap = 0;
        end
        if (bwe) model[bi] = bd & 'hFF3F;    // R10: bus write wins
        @(posedge clk);
        @(negedge clk);
        check({tag, " abort"}, int'(chk_abort), ex_abort);
        check({tag, " trap"},  int'(chk_trap),  ex_trap);
        check("R9 desc", int'(chk_desc), ex_desc);
    endtask

    task automatic peek(int m, int p, int exp, string tag);
        bus_we = 1'b0; chk_valid = 1'b0;
        bus_mode = MODE_W'(m); bus_page = SEL_W'(p);
        #1;
        check(tag, int'(bus_rdata), exp);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NIDX; i++) model[i] = 0;
        ex_desc = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 abort", int'(chk_abort), 0);
        check("R1 trap", int'(chk_trap), 0);
        check("R1 desc", int'(chk_desc), 0);
        peek(3, 15, 0, "R1 rd");
        peek(0, 0, 0, "R1 rd");
        step(0, 0, 0, 0, 1, 2, 5, 0, "R1");

        // R2: status flags in write data are dropped
        step(1, 1, 9, 'hA5C6, 0, 0, 0, 0, "R2");
        peek(1, 9, 'hA506, "R2 wr clears");

        // sweep every protection code, read then write
        for (int c = 0; c < 8; c++) begin
            step(1, 1, c, 'h1200 | c, 0, 0, 0, 0, "R2");
            step(0, 1, c, 0, 1, 1, c, 0, "R5");
            step(0, 1, c, 0, 1, 1, c, 1, "R4");
            peek(1, c, model[(1 << SEL_W) | c], "R6 status");
            step(0, 1, c, 0, 1, 1, c, 1, "R3");
            peek(1, c, model[(1 << SEL_W) | c], "R7 status");
        end
        peek(1, 6, 'h1246, "R6 free page no A");
        peek(1, 2, 'h1202, "R8 aborted write no W");
        peek(1, 4, 'h12C4, "R7 A and W");
        peek(1, 1, 'h1281, "R6 code1 read A");
        peek(1, 5, 'h12C5, "R6 code5 write A");

        // R11: same page in other mode untouched
        step(1, 2, 4, 'h0004, 0, 0, 0, 0, "R11");
        step(0, 2, 4, 0, 1, 1, 4, 1, "R11");
        peek(2, 4, 'h0004, "R11 other mode");

        // R10: collision, bus write beats status update
        step(1, 2, 4, 'h00C4, 1, 2, 4, 1, "R10");
        peek(2, 4, 'h0004, "R10 collide");

        // R9: idle cycle keeps desc, drops flags
        step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R9");

        // random traffic on a few pages
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom;
            step(r[0] & r[1], r[3:2], r[5:4], $urandom & 'hFFFF,
                 r[6] | r[7], r[9:8], r[11:10], r[12], "R6");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule